// File: doc/BRIEF.md
# Vectored Daisy-Chain Interrupt Port

This block is the interrupt front end of one I/O device sitting on a shared bus. A pulse from the device logic raises a pending request. While the device's enable flag is set, the pending request pulls a shared active-low request line low. Several such ports may share that line. The CPU answers with an acknowledge signal that runs through the ports in chain order. The first port that is requesting and enabled keeps the acknowledge for itself. That port then places a 24-bit response word on the data bus: an 8-bit vector in the upper byte and a 16-bit information field below it. When the CPU reports that it has taken the word, the port drops its request and waits for the acknowledge to fall.

A single 26-bit configuration write sets the enable flag, the vector and the information field, and can also withdraw a pending request. The request handling is a four-state machine:
- `S_IDLE`: no request.
- `S_PEND`: a request is held, and it is visible on the line only while enabled.
- `S_SERVE`: this port owns the acknowledge and drives the bus.
- `S_RELEASE`: the vector has been taken, and the port still blocks the acknowledge until it falls.

The transitions are:
- IDLE→PEND on a device event.
- PEND→IDLE on a clear write.
- PEND→SERVE when the acknowledge arrives while the port is enabled.
- SERVE→RELEASE on vector-taken.
- SERVE→PEND if the acknowledge is withdrawn first.
- RELEASE→IDLE once the acknowledge is low.

Top module: `irq_chain_port`

## Requirements
- R1: A `dev_event` pulse sampled in S_IDLE moves the port to S_PEND on that clock edge, and the request is held until it is served or cleared.
- R2: `irq_pull` is 1, and `irq_n` is driven 0, only while a request is held (S_PEND or S_SERVE) and the enable flag is 1. The enable flag is bit 25 of the configuration word.
- R3: A request taken while the port is disabled is retained. Setting the enable flag later asserts `irq_pull` without a new event.
- R4: When `ack_in` is 1 in S_PEND with the port enabled, the port enters S_SERVE. While it is in S_SERVE with `ack_in` at 1, `bus_oe` is 1 and `bus_data` carries the vector on bits 23:16 and the information field on bits 15:0. At all other times the bus is high-impedance.
- R5: `ack_out` follows `ack_in` combinationally when the port is idle or holds a masked request. It is 0 when the port is requesting and enabled, serving, or releasing, so the earliest requesting port in the chain wins.
- R6: `vec_taken` in S_SERVE clears the request and moves the port to S_RELEASE. The port stays there, with the acknowledge blocked, until `ack_in` is 0, and then returns to S_IDLE.
- R7: If `ack_in` falls in S_SERVE without `vec_taken`, the port returns to S_PEND and keeps requesting.
- R8: A configuration write with bit 24 set, made in S_PEND, withdraws the request (S_PEND→S_IDLE). Every configuration write loads enable from bit 25, the vector from bits 23:16 and the information field from bits 15:0.
- R9: After reset the port is in S_IDLE with enable, vector and information at 0. `irq_pull` and `bus_oe` are 0, and `ack_in` passes straight to `ack_out`.
- R10: When `vec_taken` and the fall of `ack_in` occur in the same cycle, vector receipt wins: the port goes to S_RELEASE and then to S_IDLE, and does not return to S_PEND.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_event | input | 1 | One-cycle pulse from the device that raises a request |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 26 | Configuration word: enable, clear, vector and information fields |
| ack_in | input | 1 | Acknowledge arriving from the CPU or the previous port |
| vec_taken | input | 1 | CPU indication that the response word was received |
| ack_out | output | 1 | Acknowledge forwarded to the next port |
| irq_pull | output | 1 | 1 while this port pulls the shared request line low |
| irq_n | output | 1 | Open-drain style request: 0 when requesting, high-impedance otherwise |
| bus_oe | output | 1 | 1 while the port drives the data bus |
| bus_data | output | 24 | Vector and information word, high-impedance when not driven |

## Verification
The acknowledge can fall in the same clock cycle in which the CPU reports that it has taken the vector. In that cycle the return-to-pending path and the release path compete. The bench raises `vec_taken` and drops `ack_in` at the same negative edge while the port is serving. It then judges the outcome at the ports: `irq_pull` must stay 0 in the following cycle, and a later acknowledge must pass straight through the idle port. A second overlap, two ports requesting at once, is judged by which port drives the bus and whether the first port forwards the acknowledge.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_PEND    = 2'd1,
        S_SERVE   = 2'd2,
        S_RELEASE = 2'd3
    } irq_state_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int VEC_W  = 8,
    parameter int INFO_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_wr,
    input  logic [VEC_W+INFO_W+1:0]   cfg_wdata,
    output logic                      en_q,
    output logic                      clr_req,
    output logic [VEC_W+INFO_W-1:0]   payload
);
    localparam int BUS_W   = VEC_W + INFO_W;
    localparam int CLR_BIT = BUS_W;
    localparam int EN_BIT  = BUS_W + 1;

    logic [VEC_W-1:0]  vec_q;
    logic [INFO_W-1:0] info_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            vec_q  <= '0;
            info_q <= '0;
        end else if (cfg_wr) begin
            en_q   <= cfg_wdata[EN_BIT];
            vec_q  <= cfg_wdata[BUS_W-1:INFO_W];
            info_q <= cfg_wdata[INFO_W-1:0];
        end
    end

    assign clr_req = cfg_wr & cfg_wdata[CLR_BIT];
    assign payload = {vec_q, info_q};
endmodule

// File: rtl/irq_req_fsm.sv
module irq_req_fsm
    import irq_chain_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dev_event,
    input  logic       ack_in,
    input  logic       vec_taken,
    input  logic       clr_req,
    input  logic       en_q,
    output irq_state_e state,
    output logic       irq_pull
);
    irq_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (dev_event) state_nx = S_PEND;
            S_PEND:    if (clr_req) state_nx = S_IDLE;
                       else if (ack_in && en_q) state_nx = S_SERVE;
            S_SERVE:   if (vec_taken) state_nx = S_RELEASE;
                       else if (!ack_in) state_nx = S_PEND;
            S_RELEASE: if (!ack_in) state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        irq_pull = 1'b0;
        unique case (state)
            S_PEND, S_SERVE: irq_pull = en_q;
            default:         irq_pull = 1'b0;
        endcase
    end

    logic serving;
    assign serving = (state == S_SERVE);

    assert_event_sets_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && dev_event) |=> (state == S_PEND));

    assert_serve_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(serving) |-> ($past(ack_in) && $past(en_q)));

    assert_taken_drops_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (serving && vec_taken) |=> !irq_pull);

    assert_tie_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (serving && vec_taken && !ack_in) |=> (state == S_RELEASE));
endmodule

// File: rtl/irq_ack_link.sv
module irq_ack_link
    import irq_chain_pkg::*;
#(
    parameter int BUS_W = 24
) (
    input  irq_state_e       state,
    input  logic             irq_pull,
    input  logic             ack_in,
    output logic             ack_out,
    output logic             bus_oe
);
    logic consume;

    always_comb begin
        unique case (state)
            S_SERVE, S_RELEASE: consume = 1'b1;
            S_PEND:             consume = irq_pull;
            default:            consume = 1'b0;
        endcase
    end

    assign ack_out = ack_in & ~consume;
    assign bus_oe  = ack_in & (state == S_SERVE);

    always_comb begin
        assert_oe_blocks_fwd_R5: assert (!(bus_oe && ack_out));
    end
endmodule

// File: rtl/irq_chain_port.sv
module irq_chain_port
    import irq_chain_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int INFO_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dev_event,
    input  logic                    cfg_wr,
    input  logic [VEC_W+INFO_W+1:0] cfg_wdata,
    input  logic                    ack_in,
    input  logic                    vec_taken,
    output logic                    ack_out,
    output logic                    irq_pull,
    output wire                     irq_n,
    output logic                    bus_oe,
    output wire [VEC_W+INFO_W-1:0]  bus_data
);
    localparam int BUS_W = VEC_W + INFO_W;

    logic             en_q;
    logic             clr_req;
    logic [BUS_W-1:0] payload;
    irq_state_e       state;

    irq_cfg_regs #(.VEC_W(VEC_W), .INFO_W(INFO_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .en_q(en_q), .clr_req(clr_req), .payload(payload)
    );

    irq_req_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .dev_event(dev_event), .ack_in(ack_in),
        .vec_taken(vec_taken), .clr_req(clr_req), .en_q(en_q),
        .state(state), .irq_pull(irq_pull)
    );

    irq_ack_link #(.BUS_W(BUS_W)) u_link (
        .state(state), .irq_pull(irq_pull), .ack_in(ack_in),
        .ack_out(ack_out), .bus_oe(bus_oe)
    );

    assign irq_n    = irq_pull ? 1'b0 : 1'bz;
    assign bus_data = bus_oe ? payload : {BUS_W{1'bz}};

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (!bus_oe && !irq_pull));

    assert_clear_withdraws_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PEND && clr_req) |=> !irq_pull);
endmodule

// File: tb/irq_chain_port_bench.sv
`timescale 1ns/1ps
module irq_chain_port_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_a = 1'b0, ev_b = 1'b0;
    logic wr_a = 1'b0, wr_b = 1'b0;
    logic [25:0] wdata = '0;
    logic ack = 1'b0, taken = 1'b0;
    logic fwd, ack_end, pull_a, pull_b, oe_a, oe_b;
    wire irq_a, irq_b;
    wire [23:0] bus_a, bus_b;
    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    irq_chain_port u_irq_chain_port (
        .clk(clk), .rst_n(rst_n), .dev_event(ev_a), .cfg_wr(wr_a), .cfg_wdata(wdata),
        .ack_in(ack), .vec_taken(taken), .ack_out(fwd), .irq_pull(pull_a),
        .irq_n(irq_a), .bus_oe(oe_a), .bus_data(bus_a)
    );
    irq_chain_port u_next (
        .clk(clk), .rst_n(rst_n), .dev_event(ev_b), .cfg_wr(wr_b), .cfg_wdata(wdata),
        .ack_in(fwd), .vec_taken(taken), .ack_out(ack_end), .irq_pull(pull_b),
        .irq_n(irq_b), .bus_oe(oe_b), .bus_data(bus_b)
    );

    // row: ev_a ev_b ack taken | pull_a pull_b oe_a oe_b fwd
    localparam logic [8:0] TBL [17] = '{
        9'b0100_00000, 9'b0000_01000, 9'b0010_01001, 9'b0010_01011,
        9'b0011_01011, 9'b0010_00001, 9'b0000_00000, 9'b1100_00000,
        9'b0000_11000, 9'b0010_11000, 9'b0010_11100, 9'b0011_11100,
        9'b0010_01000, 9'b0000_01000, 9'b0010_01001, 9'b0011_01011,
        9'b0000_00000
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic drive(input logic ea, input logic eb, input logic ak, input logic tk);
        @(negedge clk);
        ev_a = ea; ev_b = eb; ack = ak; taken = tk;
        #1;
    endtask

    task automatic cfg(input logic dev, input logic [25:0] w);
        @(negedge clk);
        ev_a = 0; ev_b = 0; ack = 0; taken = 0;
        wdata = w; wr_a = ~dev; wr_b = dev;
        @(negedge clk);
        wr_a = 0; wr_b = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R9: reset state and pass-through
        drive(0, 0, 1, 0);
        chk("R9 pull_a", pull_a, 0); chk("R9 oe_a", oe_a, 0); chk("R9 fwd", fwd, 1);
        chk("R9 pull_b", pull_b, 0);
        cfg(0, {1'b1, 1'b0, 8'h5A, 16'h1234});
        cfg(1, {1'b1, 1'b0, 8'hC3, 16'hBEEF});
        // R1 R2 R4 R5 R6: table walk
        for (int i = 0; i < 17; i++) begin
            drive(TBL[i][8], TBL[i][7], TBL[i][6], TBL[i][5]);
            chk("R1/R2 pull_a", pull_a, TBL[i][4]);
            chk("R1/R2 pull_b", pull_b, TBL[i][3]);
            chk("R4 oe_a", oe_a, TBL[i][2]);
            chk("R4 oe_b", oe_b, TBL[i][1]);
            chk("R5 fwd", fwd, TBL[i][0]);
            if (TBL[i][2]) chk("R4 bus_a", bus_a, 24'h5A1234);
            if (TBL[i][1]) chk("R4 bus_b", bus_b, 24'hC3BEEF);
        end
        // R3: masked request retained, passes acknowledge
        cfg(0, {1'b0, 1'b0, 8'h5A, 16'h1234});
        drive(1, 0, 0, 0);
        drive(0, 0, 1, 0);
        chk("R2 masked pull_a", pull_a, 0);
        chk("R5 masked fwd", fwd, 1);
        chk("R3 masked oe_a", oe_a, 0);
        drive(0, 0, 0, 0);
        cfg(0, {1'b1, 1'b0, 8'h5A, 16'h1234});
        drive(0, 0, 0, 0);
        chk("R3 enabled pull_a", pull_a, 1);
        // R7: acknowledge withdrawn during serve
        drive(0, 0, 1, 0);
        drive(0, 0, 1, 0);
        chk("R7 oe_a serving", oe_a, 1);
        drive(0, 0, 0, 0);
        chk("R7 oe_a dropped", oe_a, 0);
        drive(0, 0, 0, 0);
        chk("R7 pull_a again", pull_a, 1);
        // R8: clear write withdraws request
        cfg(0, {1'b1, 1'b1, 8'h5A, 16'h1234});
        drive(0, 0, 1, 0);
        chk("R8 pull_a", pull_a, 0);
        chk("R8 fwd", fwd, 1);
        // R10: taken and ack fall in the same cycle
        drive(1, 0, 0, 0);
        drive(0, 0, 1, 0);
        drive(0, 0, 1, 0);
        chk("R10 serving", oe_a, 1);
        drive(0, 0, 0, 1);
        chk("R10 oe_a", oe_a, 0);
        drive(0, 0, 0, 0);
        chk("R10 pull_a", pull_a, 0);
        drive(0, 0, 1, 0);
        chk("R10 fwd idle", fwd, 1);
        chk("R10 ack_end", ack_end, 1);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog got=hung exp=done");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule